// File: doc/BRIEF.md
# Biphase Framed Message Transmitter

The block turns a message of one or more 8-bit words into a single-ended Manchester (biphase) line level. Every half bit-time lasts `HALF_DIV` system clocks. An internal divider makes this timing and restarts with each message. A message opens with a preamble of quiesce pulses and a three bit-time code violation. It then carries one frame per word. It closes with a format-specific tail and an optional hold of the final level.

Two framings are selectable at message start. The first uses 12-bit frames sent back to back and closes with an explicit ending pattern. A variant of it inserts an 8-bit address frame ahead of the data frames. The second framing inverts the line polarity, uses 16-bit frames, can insert fill bits between frames, and closes with three fill bits.

Words arrive through a valid/ready handshake. The ready pulse lasts one clock and marks the moment a frame slot is filled. A last-word flag closes the message. A missing word at that moment also closes it.

Top module: `biphase_msg_tx`

## Requirements
- R1: After reset and whenever no message is in progress, `line_o`, `busy_o` and `word_ready_o` are all 0.
- R2: A `start_i` seen while idle begins a message on that clock edge. `mode_i`, `fill_cnt_i`, `hold_cnt_i` and `addr_i` are captured at that edge. Changes to `start_i` or to those inputs while busy have no effect on the line.
- R3: `line_o` changes only at half-bit boundaries. The first half-bit starts at the edge that accepts `start_i`, and each half-bit lasts `HALF_DIV` clocks.
- R4: `mode_i` 2'b00 selects 12-bit framing, 2'b01 selects 12-bit framing with an address frame, and 2'b1x selects 16-bit framing. In the 12-bit framings a 1 is sent as low then high and a 0 as high then low. The 16-bit framing inverts every encoded bit and the preamble.
- R5: Each message opens with five encoded 1 bits. A code violation follows: three half-bits low, then three half-bits high (inverted in 16-bit framing). The first frame comes next.
- R6: A 12-bit frame is sent in this order: a sync 1, `word_data_i` from bit 7 down to bit 0, `word_ctrl_i[1]`, `word_ctrl_i[0]`, and a parity bit equal to the XOR of the previous 11 bits. Frames follow each other with no gap.
- R7: After the final 12-bit frame, the line carries an encoded 0 followed by four half-bits high.
- R8: A 16-bit frame is sent in this order: a sync 1, `word_data_i` from bit 0 up to bit 7, `word_ctrl_i[0]`, `[1]` and `[2]`, a parity bit equal to the XOR of the previous 12 bits, and three encoded 0 bits.
- R9: In 16-bit framing, `fill_cnt_i` encoded 0 bits follow every frame that was not flagged last. The message closes with three encoded 0 bits.
- R10: In the address variant, the first frame is a sync 1, then `addr_i[2]`, `addr_i[1]`, `addr_i[0]`, then three 0 bits, then a parity bit equal to the XOR of the previous 7 bits.
- R11: `word_ready_o` pulses for one clock at the last clock of the bit-time before each frame slot. A word is taken when `word_valid_i` is high in that clock. `word_last_i` makes the taken word the final frame. If `word_valid_i` is low, the message closes at once.
- R12: After the closing pattern, the last line level is held for 2*`hold_cnt_i` half-bits. After that, `line_o` goes low and `busy_o` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a message (sampled when idle) |
| mode_i | input | 2 | Framing selection |
| fill_cnt_i | input | 4 | Inter-frame fill bits, 16-bit framing |
| hold_cnt_i | input | HOLD_W | Bit-times to hold the final level |
| addr_i | input | 3 | Address for the address frame |
| word_valid_i | input | 1 | Word available |
| word_data_i | input | 8 | Word payload |
| word_ctrl_i | input | 3 | Control field (12-bit) or station field (16-bit) |
| word_last_i | input | 1 | Word is the last of the message |
| word_ready_o | output | 1 | Word accepted this clock if valid |
| line_o | output | 1 | Encoded line level |
| busy_o | output | 1 | Message in progress |

## Verification
The assertions check the following on every cycle:
- the line is low while idle;
- the line moves only in the clock after a half-bit tick or an accepted start;
- the first half-bit of the preamble has the level that matches the captured polarity;
- the ready pulse lasts one clock and appears only during a message.

The bench's scenarios cover the rest. Each scenario compares the full half-bit waveform against a model built from the frame layouts, parity, fill counts, ending patterns and hold lengths. The scenarios also cover closing on a missing word and ignoring inputs while busy.

// File: rtl/biphase_tx_pkg.sv
package biphase_tx_pkg;
  localparam int FRAME_MAX = 16;
  localparam int FILL_W    = 4;
  localparam int PRE_BITS  = 5;
  localparam int CV_BITS   = 3;
  localparam int CLOSE_BITS = 3;
  localparam int LEN_A     = 12;
  localparam int LEN_B     = 16;
  localparam int LEN_ADDR  = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_CV, ST_ADDR, ST_FRAME, ST_FILL, ST_TAIL, ST_END, ST_HOLD
  } tx_state_e;
endpackage

// File: rtl/biphase_half_tick.sv
module biphase_half_tick #(
  parameter int HALF_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       div_q <= '0;
    else if (!run_i || tick_o)         div_q <= '0;
    else                               div_q <= div_q + DW'(1);
  end

  assign tick_o = run_i && (div_q == DW'(HALF_DIV - 1));
endmodule

// File: rtl/biphase_frame_build.sv
module biphase_frame_build
  import biphase_tx_pkg::*;
(
  input  logic                 sel_addr_i,
  input  logic                 fmt_b_i,
  input  logic [7:0]           data_i,
  input  logic [2:0]           ctrl_i,
  input  logic [2:0]           addr_i,
  output logic [FRAME_MAX-1:0] frame_o,
  output logic [3:0]           last_idx_o
);
  logic [7:0] data_rev;

  for (genvar i = 0; i < 8; i++) begin : g_rev
    assign data_rev[i] = data_i[7-i];
  end

  // frames are left aligned, the MSB goes out first
  always_comb begin
    if (sel_addr_i) begin
      frame_o    = {1'b1, addr_i, 3'b000, ^{1'b1, addr_i}, 8'h00};
      last_idx_o = 4'(LEN_ADDR - 1);
    end else if (fmt_b_i) begin
      frame_o    = {1'b1, data_rev, ctrl_i[0], ctrl_i[1], ctrl_i[2],
                    ^{1'b1, data_i, ctrl_i}, 3'b000};
      last_idx_o = 4'(LEN_B - 1);
    end else begin
      frame_o    = {1'b1, data_i, ctrl_i[1:0], ^{1'b1, data_i, ctrl_i[1:0]}, 4'h0};
      last_idx_o = 4'(LEN_A - 1);
    end
  end
endmodule

// File: rtl/biphase_msg_tx.sv
module biphase_msg_tx
  import biphase_tx_pkg::*;
#(
  parameter int HALF_DIV = 8,
  parameter int HOLD_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [FILL_W-1:0] fill_cnt_i,
  input  logic [HOLD_W-1:0] hold_cnt_i,
  input  logic [2:0]        addr_i,
  input  logic              word_valid_i,
  input  logic [7:0]        word_data_i,
  input  logic [2:0]        word_ctrl_i,
  input  logic              word_last_i,
  output logic              word_ready_o,
  output logic              line_o,
  output logic              busy_o
);
  localparam int CW = (HOLD_W > FILL_W) ? HOLD_W : FILL_W;

  tx_state_e            st_q, st_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 half_q, half_d;
  logic [FRAME_MAX-1:0] shf_q, shf_d;
  logic [3:0]           len_q, len_d;
  logic                 last_q, last_d;
  logic                 fmt_b_q, fmt_b_d;
  logic                 addr_mode_q;
  logic [FILL_W-1:0]    fill_q;
  logic [HOLD_W-1:0]    hold_q;
  logic [2:0]           addr_q;
  logic                 line_q, line_d;
  logic                 half_tick;
  logic                 fetch, close;
  logic                 lvl;
  logic [FRAME_MAX-1:0] frm;
  logic [3:0]           frm_last;

  biphase_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q != ST_IDLE),
    .tick_o (half_tick)
  );

  biphase_frame_build u_frame (
    .sel_addr_i (st_q == ST_CV && addr_mode_q),
    .fmt_b_i    (fmt_b_q),
    .data_i     (word_data_i),
    .ctrl_i     (word_ctrl_i),
    .addr_i     (addr_q),
    .frame_o    (frm),
    .last_idx_o (frm_last)
  );

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    half_d  = half_q;
    shf_d   = shf_q;
    len_d   = len_q;
    last_d  = last_q;
    fmt_b_d = fmt_b_q;
    fetch   = 1'b0;
    close   = 1'b0;
    if (st_q == ST_IDLE) begin
      if (start_i) begin
        st_d    = ST_PRE;
        cnt_d   = '0;
        half_d  = 1'b0;
        fmt_b_d = mode_i[1];
      end
    end else if (half_tick) begin
      half_d = ~half_q;
      if (half_q) begin
        cnt_d = cnt_q + CW'(1);
        shf_d = {shf_q[FRAME_MAX-2:0], 1'b0};
        case (st_q)
          ST_PRE: if (cnt_q == CW'(PRE_BITS - 1)) begin
            st_d  = ST_CV;
            cnt_d = '0;
          end
          ST_CV: if (cnt_q == CW'(CV_BITS - 1)) begin
            if (addr_mode_q) begin
              st_d  = ST_ADDR;
              cnt_d = '0;
              shf_d = frm;
              len_d = frm_last;
            end else fetch = 1'b1;
          end
          ST_ADDR: if (cnt_q == CW'(len_q)) fetch = 1'b1;
          ST_FRAME: if (cnt_q == CW'(len_q)) begin
            if (last_q) close = 1'b1;
            else if (fmt_b_q && fill_q != '0) begin
              st_d  = ST_FILL;
              cnt_d = '0;
            end else fetch = 1'b1;
          end
          ST_FILL: if (cnt_q == CW'(fill_q) - CW'(1)) fetch = 1'b1;
          ST_TAIL, ST_END: if (cnt_q == CW'(CLOSE_BITS - 1)) begin
            if (hold_q != '0) begin
              st_d  = ST_HOLD;
              cnt_d = '0;
            end else st_d = ST_IDLE;
          end
          ST_HOLD: if (cnt_q == CW'(hold_q) - CW'(1)) st_d = ST_IDLE;
          default: st_d = ST_IDLE;
        endcase
        if (fetch) begin
          if (word_valid_i) begin
            st_d   = ST_FRAME;
            cnt_d  = '0;
            shf_d  = frm;
            len_d  = frm_last;
            last_d = word_last_i;
          end else close = 1'b1;
        end
        if (close) begin
          st_d  = fmt_b_q ? ST_TAIL : ST_END;
          cnt_d = '0;
        end
      end
    end
  end

  // level of the half-bit about to start, before polarity inversion
  always_comb begin
    case (st_d)
      ST_PRE:            lvl = half_d;
      ST_CV:             lvl = (cnt_d >= CW'(2)) || (cnt_d == CW'(1) && half_d);
      ST_ADDR, ST_FRAME: lvl = half_d ? shf_d[FRAME_MAX-1] : ~shf_d[FRAME_MAX-1];
      ST_FILL, ST_TAIL:  lvl = ~half_d;
      ST_END:            lvl = (cnt_d == '0) ? ~half_d : 1'b1;
      default:           lvl = 1'b0;
    endcase
    case (st_d)
      ST_IDLE: line_d = 1'b0;
      ST_HOLD: line_d = line_q;
      ST_END:  line_d = lvl;
      default: line_d = lvl ^ fmt_b_d;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      half_q      <= 1'b0;
      shf_q       <= '0;
      len_q       <= '0;
      last_q      <= 1'b0;
      fmt_b_q     <= 1'b0;
      addr_mode_q <= 1'b0;
      fill_q      <= '0;
      hold_q      <= '0;
      addr_q      <= '0;
      line_q      <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      half_q  <= half_d;
      shf_q   <= shf_d;
      len_q   <= len_d;
      last_q  <= last_d;
      fmt_b_q <= fmt_b_d;
      line_q  <= line_d;
      if (st_q == ST_IDLE && start_i) begin
        addr_mode_q <= (mode_i == 2'b01);
        fill_q      <= fill_cnt_i;
        hold_q      <= hold_cnt_i;
        addr_q      <= addr_i;
      end
    end
  end

  assign word_ready_o = fetch;
  assign line_o       = line_q;
  assign busy_o       = (st_q != ST_IDLE);
endmodule

// File: rtl/biphase_msg_tx_chk.sv
module biphase_msg_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [1:0] mode_i,
  input logic       busy_o,
  input logic       line_o,
  input logic       word_ready_o,
  input logic       tick_i
);
  assert_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !line_o);

  assert_ready_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ready_o |-> busy_o);

  assert_line_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tick_i) && !$past(start_i && !busy_o)) |-> $stable(line_o));

  assert_pre_polarity_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (line_o == $past(mode_i[1])));

  assert_ready_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ready_o |=> !word_ready_o);
endmodule

bind biphase_msg_tx biphase_msg_tx_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .mode_i       (mode_i),
  .busy_o       (busy_o),
  .line_o       (line_o),
  .word_ready_o (word_ready_o),
  .tick_i       (half_tick)
);

// File: tb/test_biphase_msg_tx.sv
module test_biphase_msg_tx;
  localparam int HALF_DIV = 4;
  localparam int HOLD_W   = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [3:0] fill_cnt_i = '0;
  logic [HOLD_W-1:0] hold_cnt_i = '0;
  logic [2:0] addr_i = '0;
  logic word_valid_i = 1'b0;
  logic [7:0] word_data_i = '0;
  logic [2:0] word_ctrl_i = '0;
  logic word_last_i = 1'b0;
  logic word_ready_o, line_o, busy_o;

  int n_checks = 0;
  int n_fail = 0;

  logic exp_lvl [0:1023];
  int   exp_n;
  logic [7:0] wd [0:7];
  logic [2:0] wc [0:7];

  always #4 clk = ~clk;

  biphase_msg_tx #(.HALF_DIV(HALF_DIV), .HOLD_W(HOLD_W)) i_biphase_msg_tx (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .fill_cnt_i(fill_cnt_i), .hold_cnt_i(hold_cnt_i), .addr_i(addr_i),
    .word_valid_i(word_valid_i), .word_data_i(word_data_i), .word_ctrl_i(word_ctrl_i),
    .word_last_i(word_last_i), .word_ready_o(word_ready_o), .line_o(line_o), .busy_o(busy_o)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_half(logic l);
    exp_lvl[exp_n] = l;
    exp_n++;
  endtask

  task automatic push_bit(logic b, logic inv);
    push_half(~b ^ inv);
    push_half(b ^ inv);
  endtask

  task automatic build_exp(logic [1:0] md, logic [3:0] fl, logic [3:0] hd,
                           logic [2:0] ad, int nw, bit lastf);
    logic inv = md[1];
    logic p;
    logic l;
    exp_n = 0;
    repeat (5) push_bit(1'b1, inv);
    repeat (3) push_half(1'b0 ^ inv);
    repeat (3) push_half(1'b1 ^ inv);
    if (md == 2'b01) begin
      p = 1'b1; push_bit(1'b1, 1'b0);
      for (int i = 2; i >= 0; i--) begin push_bit(ad[i], 1'b0); p ^= ad[i]; end
      repeat (3) push_bit(1'b0, 1'b0);
      push_bit(p, 1'b0);
    end
    for (int w = 0; w < nw; w++) begin
      p = 1'b1; push_bit(1'b1, inv);
      if (inv) begin
        for (int i = 0; i < 8; i++) begin push_bit(wd[w][i], inv); p ^= wd[w][i]; end
        for (int i = 0; i < 3; i++) begin push_bit(wc[w][i], inv); p ^= wc[w][i]; end
        push_bit(p, inv);
        repeat (3) push_bit(1'b0, inv);
        if (!(lastf && w == nw - 1)) repeat (fl) push_bit(1'b0, inv);
      end else begin
        for (int i = 7; i >= 0; i--) begin push_bit(wd[w][i], 1'b0); p ^= wd[w][i]; end
        for (int i = 1; i >= 0; i--) begin push_bit(wc[w][i], 1'b0); p ^= wc[w][i]; end
        push_bit(p, 1'b0);
      end
    end
    if (inv) repeat (3) push_bit(1'b0, inv);
    else begin
      push_bit(1'b0, 1'b0);
      repeat (4) push_half(1'b1);
    end
    l = exp_lvl[exp_n-1];
    repeat (2 * hd) push_half(l);
  endtask

  task automatic run_msg(string req, logic [1:0] md, logic [3:0] fl, logic [3:0] hd,
                         logic [2:0] ad, int nw, bit lastf, bit disturb);
    int mism = 0, first_bad = -1, busy_bad = 0, acc = 0;
    logic end_busy, end_line, act_at_bad, exp_at_bad;
    bit done = 0;
    build_exp(md, fl, hd, ad, nw, lastf);
    @(negedge clk);
    mode_i = md; fill_cnt_i = fl; hold_cnt_i = hd; addr_i = ad; start_i = 1'b1;
    word_valid_i = (nw > 0); word_data_i = wd[0]; word_ctrl_i = wc[0];
    word_last_i = lastf && (nw == 1);
    @(posedge clk);
    #1 start_i = 1'b0;
    fork
      begin
        for (int k = 0; k <= exp_n; k++) begin
          @(negedge clk);
          if (k < exp_n) begin
            if (line_o !== exp_lvl[k]) begin
              if (mism == 0) begin
                first_bad = k; act_at_bad = line_o; exp_at_bad = exp_lvl[k];
              end
              mism++;
            end
            if (busy_o !== 1'b1) busy_bad++;
          end else begin
            end_busy = busy_o; end_line = line_o;
          end
          if (disturb && k == 10) begin
            start_i = 1'b1; mode_i = ~md; fill_cnt_i = ~fl; hold_cnt_i = ~hd;
          end
          for (int j = 1; j < HALF_DIV; j++) begin
            @(negedge clk);
            start_i = 1'b0;
          end
        end
        done = 1;
      end
      begin
        while (!done) begin
          @(negedge clk);
          if (!done && word_ready_o && word_valid_i) begin
            acc++;
            @(posedge clk);
            #1;
            if (acc < nw) begin
              word_data_i = wd[acc]; word_ctrl_i = wc[acc];
              word_last_i = lastf && (acc == nw - 1);
            end else begin
              word_valid_i = 1'b0; word_last_i = 1'b0;
            end
          end
        end
      end
    join
    word_valid_i = 1'b0;
    if (mism != 0)
      $display("  first mismatch at half-bit %0d: actual %0b expected %0b",
               first_bad, act_at_bad, exp_at_bad);
    check(mism == 0, req, "line waveform mismatching half-bits", mism, 0);
    check(busy_bad == 0 && end_busy === 1'b0 && end_line === 1'b0, req,
          "busy span / idle after message (R12)", busy_bad + int'(end_busy) + int'(end_line), 0);
    check(acc == nw, req, "words accepted (R11)", acc, nw);
  endtask

  // R1
  task automatic t_reset;
    @(negedge clk);
    check(line_o === 1'b0, "R1", "line after reset", int'(line_o), 0);
    check(busy_o === 1'b0, "R1", "busy after reset", int'(busy_o), 0);
    check(word_ready_o === 1'b0, "R1", "ready after reset", int'(word_ready_o), 0);
  endtask

  // R2 R3 R4 R5 R6 R7: three words, start and config toggled mid-message
  task automatic t_fmt_a;
    wd[0] = 8'hA5; wc[0] = 3'b010;
    wd[1] = 8'h3C; wc[1] = 3'b001;
    wd[2] = 8'hFF; wc[2] = 3'b011;
    run_msg("R2 R5 R6 R7", 2'b00, 4'd0, 4'd0, 3'd0, 3, 1'b1, 1'b1);
  endtask

  // R10 R12
  task automatic t_fmt_a_addr;
    wd[0] = 8'h81; wc[0] = 3'b000;
    wd[1] = 8'h5E; wc[1] = 3'b110;
    run_msg("R10 R12", 2'b01, 4'd0, 4'd2, 3'b101, 2, 1'b1, 1'b0);
  endtask

  // R4 R8 R9 R12
  task automatic t_fmt_b_fill;
    wd[0] = 8'h12; wc[0] = 3'b101;
    wd[1] = 8'hC7; wc[1] = 3'b011;
    run_msg("R4 R8 R9", 2'b10, 4'd2, 4'd1, 3'd0, 2, 1'b1, 1'b0);
  endtask

  // R8 R9 with no fill, single word
  task automatic t_fmt_b_single;
    wd[0] = 8'h6B; wc[0] = 3'b111;
    run_msg("R8 R9", 2'b11, 4'd0, 4'd0, 3'd0, 1, 1'b1, 1'b0);
  endtask

  // R11: no last flag, source runs dry
  task automatic t_underrun;
    wd[0] = 8'h0F; wc[0] = 3'b001;
    wd[1] = 8'hF0; wc[1] = 3'b010;
    run_msg("R11", 2'b00, 4'd0, 4'd1, 3'd0, 2, 1'b0, 1'b0);
  endtask

  // R11 R9: empty message, 16-bit framing
  task automatic t_empty_b;
    run_msg("R11 R9", 2'b10, 4'd3, 4'd0, 3'd0, 0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_fmt_a();
    t_fmt_a_addr();
    t_fmt_b_fill();
    t_fmt_b_single();
    t_underrun();
    t_empty_b();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule